// File: doc/BRIEF.md
# Parallel port EPP transfer gate

This block sits between a host register window and an external peripheral. It runs Enhanced Parallel Port address and data transfers over a byte-wide request/acknowledge handshake. The host window has eight byte offsets. It holds the data latch, the status view and the control register, which the block owns, plus the two EPP transfer registers. A transfer starts only when the stored control value puts the port in the correct mode for that direction. A transfer in the wrong mode is dropped: a write has no effect, and a read returns all ones.

Each byte of a transfer is a handshake with a limit on how many cycles the acknowledge may take. If the peripheral reports an error, or never acknowledges, the block sets a sticky timeout flag and drops the rest of the access. The flag shows in bit 0 of the status read, and software clears it by writing a 1 to that bit. Accesses to the EPP data register may be 1, 2 or 4 bytes wide. The bytes move least significant first. The host waits for a one-cycle completion pulse before it issues the next access.

Top module: `epp_gate`

## Requirements
- R1: After reset the control register reads 0xCC, the data latch reads 0xFF and the timeout flag is 0.
- R2: The offsets are: 0 data latch, 1 status, 2 control, 3 EPP address, 4 EPP data. A read of offsets 5 to 7 returns 0xFF, and a write to them has no effect.
- R3: A control write stores the written byte with bits 7:6 forced to 1. A data or control write equal to the stored value is skipped and gives no update pulse. A write that changes the stored value gives a one-cycle update pulse.
- R4: An EPP write (offset 3 or 4) runs only when the control value ANDed with 0x2F equals 0x04. Otherwise it raises no peripheral request and leaves the timeout flag unchanged.
- R5: An EPP read runs only when the control value ANDed with 0x2F equals 0x24. Otherwise it returns all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF.
- R6: The access size code is 0 for 1 byte, 1 for 2 bytes and 2 or 3 for 4 bytes, and it applies at offset 4. The bytes move least significant first. Offset 3 always moves one byte. The peripheral-side address flag is 1 only for offset 3.
- R7: The request for a byte is held for at most ack_limit+1 cycles. An acknowledge arriving in that window completes the byte. Without one, the byte times out.
- R8: An error on acknowledge, or a timeout, sets the timeout flag and abandons the remaining bytes. In read data, a byte that failed or was abandoned reads 0xFF. The flag stays set through later successful transfers.
- R9: A status read returns peripheral status bits 7:1 with bit 0 replaced by the timeout flag. A status write with bit 0 set clears the flag, and one with bit 0 clear has no effect.
- R10: Register-only accesses complete one cycle after they are accepted. A single-byte EPP access whose acknowledge arrives d cycles after the request completes d+1 cycles after it is accepted. A request made while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 write, 0 read |
| host_addr | input | 3 | Byte offset in window |
| host_size | input | 2 | Access width code (R6) |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ready |
| data_q | output | 8 | Stored data latch |
| ctrl_q | output | 8 | Stored control value |
| data_upd | output | 1 | Data latch changed |
| ctrl_upd | output | 1 | Control value changed |
| ack_limit | input | LIMIT_W | Handshake cycle limit |
| per_status | input | 8 | Peripheral status lines |
| per_req | output | 1 | Byte transfer request |
| per_write | output | 1 | Transfer direction, 1 write |
| per_is_addr | output | 1 | Address cycle flag |
| per_wdata | output | 8 | Byte to peripheral |
| per_rdata | input | 8 | Byte from peripheral |
| per_ack | input | 1 | Peripheral acknowledge |
| per_err | input | 1 | Failure reported with acknowledge |

## Verification
A timeout flag that sets or clears wrongly shows in bit 0 of the next status read, so each transfer is followed by a status read. A wrong byte index shows in the first multi-byte transfer as swapped lanes or extra peripheral bytes. An off-by-one in the handshake counter decides the outcome of a transfer whose acknowledge lands on the last allowed cycle, so the limit boundary is tested on both sides. A gate decoded from the wrong control bits shows at once, as a request on the peripheral side or as a read value other than all ones.

// File: rtl/epp_gate.sv
module epp_gate #(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [2:0]         host_addr,
  input  logic [1:0]         host_size,
  input  logic [31:0]        host_wdata,
  output logic               host_ready,
  output logic [31:0]        host_rdata,
  output logic [7:0]         data_q,
  output logic [7:0]         ctrl_q,
  output logic               data_upd,
  output logic               ctrl_upd,
  input  logic [LIMIT_W-1:0] ack_limit,
  input  logic [7:0]         per_status,
  output logic               per_req,
  output logic               per_write,
  output logic               per_is_addr,
  output logic [7:0]         per_wdata,
  input  logic [7:0]         per_rdata,
  input  logic               per_ack,
  input  logic               per_err
);

  logic               busy, req_q, wr_q, isaddr_q, tmo;
  logic [1:0]         idx, last;
  logic [31:0]        wbuf, rbuf, rbuf_nx, imm_rd;
  logic [LIMIT_W-1:0] cnt;

  wire       accept    = host_req && !busy;
  wire [7:0] ctl_m     = ctrl_q & 8'h2F;
  wire       epp_sel   = (host_addr == 3'd3) || (host_addr == 3'd4);
  wire       gate_ok   = host_we ? (ctl_m == 8'h04) : (ctl_m == 8'h24);
  wire [1:0] nlast     = (host_addr == 3'd3) ? 2'd0 :
                         host_size[1] ? 2'd3 : {1'b0, host_size[0]};
  wire [31:0] ones_w   = (nlast == 2'd3) ? 32'hFFFF_FFFF :
                         (nlast == 2'd1) ? 32'h0000_FFFF : 32'h0000_00FF;
  wire [7:0] ctl_new   = host_wdata[7:0] | 8'hC0;
  wire       byte_done = req_q && per_ack;
  wire       timed     = req_q && !per_ack && (cnt == ack_limit);
  wire       fail      = timed || (byte_done && per_err);
  wire       finish    = fail || (byte_done && idx == last);

  assign per_req     = req_q;
  assign per_write   = wr_q;
  assign per_is_addr = isaddr_q;
  assign per_wdata   = wbuf[{idx, 3'b000} +: 8];

  always_comb begin
    rbuf_nx = rbuf;
    if (byte_done && !per_err) rbuf_nx[{idx, 3'b000} +: 8] = per_rdata;
  end

  always_comb begin
    case (host_addr)
      3'd0:    imm_rd = {24'h0, data_q};
      3'd1:    imm_rd = {24'h0, per_status[7:1], tmo};
      3'd2:    imm_rd = {24'h0, ctrl_q};
      3'd3,
      3'd4:    imm_rd = ones_w;
      default: imm_rd = 32'h0000_00FF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; req_q <= 1'b0; wr_q <= 1'b0; isaddr_q <= 1'b0;
      idx <= '0; last <= '0; cnt <= '0; wbuf <= '0; rbuf <= '0;
      tmo <= 1'b0; data_q <= 8'hFF; ctrl_q <= 8'hCC;
      host_ready <= 1'b0; host_rdata <= '0; data_upd <= 1'b0; ctrl_upd <= 1'b0;
    end else begin
      host_ready <= 1'b0;
      data_upd   <= 1'b0;
      ctrl_upd   <= 1'b0;
      if (accept) begin
        if (epp_sel && gate_ok) begin
          busy <= 1'b1; req_q <= 1'b1; cnt <= '0; idx <= '0; last <= nlast;
          wr_q <= host_we; isaddr_q <= (host_addr == 3'd3);
          wbuf <= host_wdata; rbuf <= ones_w;
        end else begin
          host_ready <= 1'b1;
          if (!host_we) host_rdata <= imm_rd;
          else begin
            case (host_addr)
              3'd0: if (host_wdata[7:0] != data_q) begin
                data_q <= host_wdata[7:0]; data_upd <= 1'b1;
              end
              3'd1: if (host_wdata[0]) tmo <= 1'b0;
              3'd2: if (ctl_new != ctrl_q) begin
                ctrl_q <= ctl_new; ctrl_upd <= 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
      if (busy) begin
        if (req_q) begin
          cnt <= cnt + 1'b1;
          if (byte_done || timed) req_q <= 1'b0;
          if (!wr_q) rbuf <= rbuf_nx;
          if (fail) tmo <= 1'b1;
          if (finish) begin
            busy <= 1'b0;
            host_ready <= 1'b1;
            if (!wr_q) host_rdata <= rbuf_nx;
          end
        end else begin
          req_q <= 1'b1;
          cnt   <= '0;
          idx   <= idx + 2'd1;
        end
      end
    end
  end

  p_wr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && per_write |-> (ctrl_q & 8'h2F) == 8'h04);

  p_rd_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && !per_write |-> (ctrl_q & 8'h2F) == 8'h24);

  p_ctrl_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7:6] == 2'b11);

  p_req_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && !per_ack && cnt == ack_limit |=> !per_req);

  p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo && !(accept && host_we && host_addr == 3'd1 && host_wdata[0]) |=> tmo);

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> !per_req);

endmodule

// File: tb/epp_gate_tb_top.sv
module epp_gate_tb_top;
  localparam int LW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 0, host_we = 0;
  logic [2:0] host_addr = 0;
  logic [1:0] host_size = 0;
  logic [31:0] host_wdata = 0;
  logic host_ready, data_upd, ctrl_upd;
  logic [31:0] host_rdata;
  logic [7:0] data_q, ctrl_q;
  logic [LW-1:0] ack_limit = 8'd3;
  logic [7:0] per_status = 8'hA5;
  logic per_req, per_write, per_is_addr;
  logic [7:0] per_wdata;
  logic [7:0] per_rdata = 0;
  logic per_ack = 0, per_err = 0;

  always #2 clk = ~clk;

  epp_gate #(.LIMIT_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rdata(host_rdata), .data_q(data_q),
    .ctrl_q(ctrl_q), .data_upd(data_upd), .ctrl_upd(ctrl_upd),
    .ack_limit(ack_limit), .per_status(per_status), .per_req(per_req),
    .per_write(per_write), .per_is_addr(per_is_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_ack(per_ack), .per_err(per_err));

  int checks = 0, fails = 0;
  logic [7:0] m_log [4];
  bit m_alog [4];
  int m_dly [4];
  bit m_err [4];
  int m_nlog = 0, m_pc = 0, m_byte = 0;
  bit m_prev = 0;
  logic [7:0] m_pat = 8'h50;

  always @(negedge clk) begin
    if (per_req) begin
      if (!per_ack) begin
        m_pc++;
        if (m_pc == m_dly[m_byte]) begin
          per_ack = 1; per_err = m_err[m_byte]; per_rdata = m_pat + 8'(m_byte);
          if (per_write && m_nlog < 4) begin
            m_log[m_nlog] = per_wdata; m_alog[m_nlog] = per_is_addr; m_nlog++;
          end
        end
      end
    end else begin
      per_ack = 0; per_err = 0; m_pc = 0;
      if (m_prev && m_byte < 3) m_byte++;
    end
    m_prev = per_req;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setm(int d, bit e);
    for (int i = 0; i < 4; i++) begin m_dly[i] = d; m_err[i] = e; end
    m_nlog = 0; m_byte = 0; m_pc = 0;
  endtask

  logic [31:0] t_rd;
  int t_lat;
  bit t_du, t_cu;

  task automatic acc(bit we, logic [2:0] a, logic [1:0] sz, logic [31:0] wd);
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
    t_lat = 0;
    @(negedge clk);
    host_req = 0;
    t_lat = 1;
    while (!host_ready && t_lat < 300) begin @(negedge clk); t_lat++; end
    if (!host_ready) begin
      fails++; checks++;
      $display("FAIL R10 access hung actual=%0d expected<300", t_lat);
    end
    t_rd = host_rdata; t_du = data_upd; t_cu = ctrl_upd;
  endtask

  function automatic logic [31:0] ones_of(int nb);
    return nb == 4 ? 32'hFFFFFFFF : nb == 2 ? 32'hFFFF : 32'hFF;
  endfunction

  bit tmo_e = 0;
  logic [7:0] ctl_e = 8'hCC;

  task automatic epp_run(bit we, logic [2:0] a, logic [1:0] sz, logic [31:0] wd, string tag);
    int nb, acked, okc;
    bit failed, gate;
    logic [31:0] exp_rd;
    nb = (a == 3) ? 1 : (sz[1] ? 4 : (sz[0] ? 2 : 1));
    gate = we ? ((ctl_e & 8'h2F) == 8'h04) : ((ctl_e & 8'h2F) == 8'h24);
    acked = 0; okc = 0; failed = 0;
    if (gate) begin
      for (int i = 0; i < nb; i++) begin
        if (m_dly[i] > int'(ack_limit) + 1) begin failed = 1; break; end
        acked++;
        if (m_err[i]) begin failed = 1; break; end
        okc++;
      end
    end
    exp_rd = ones_of(nb);
    if (gate) for (int i = 0; i < okc; i++) exp_rd[i*8 +: 8] = m_pat + 8'(i);
    acc(we, a, sz, wd);
    if (!we) chk({tag, " read data"}, t_rd, exp_rd);
    chk({tag, " bytes to peripheral"}, m_nlog, we ? acked : 0);
    if (we) for (int i = 0; i < acked; i++) begin
      chk({tag, " byte lane"}, {24'h0, m_log[i]}, {24'h0, wd[i*8 +: 8]});
      chk({tag, " addr flag"}, {31'h0, m_alog[i]}, {31'h0, a == 3});
    end
    if (failed) tmo_e = 1;
    acc(0, 1, 0, 0);
    chk({tag, " R9 status"}, t_rd, {24'h0, per_status[7:1], tmo_e});
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    setm(1, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    acc(0, 2, 0, 0); chk("R1 control", t_rd, 32'hCC);
    acc(0, 0, 0, 0); chk("R1 data", t_rd, 32'hFF);
    acc(0, 1, 0, 0); chk("R1 R9 status", t_rd, 32'hA4);
    chk("R10 register latency", t_lat, 1);
    acc(0, 6, 0, 0); chk("R2 unused read", t_rd, 32'hFF);
    acc(1, 5, 0, 32'h12); acc(0, 2, 0, 0); chk("R2 unused write", t_rd, 32'hCC);
    // gates closed at reset value
    setm(1, 0);
    epp_run(1, 4, 2, 32'hDEADBEEF, "R4 closed");
    epp_run(0, 4, 1, 0, "R5 closed");
    epp_run(0, 4, 2, 0, "R5 closed 4B");
    // R3 control and data writes
    acc(1, 2, 0, 32'h04); chk("R3 ctrl pulse", t_cu, 1); ctl_e = 8'hC4;
    acc(0, 2, 0, 0); chk("R3 ctrl forced", t_rd, 32'hC4);
    acc(1, 2, 0, 32'hC4); chk("R3 equal ctrl skipped", t_cu, 0);
    acc(1, 0, 0, 32'h3C); chk("R3 data pulse", t_du, 1);
    acc(1, 0, 0, 32'h3C); chk("R3 equal data skipped", t_du, 0);
    acc(0, 0, 0, 0); chk("R3 data value", t_rd, 32'h3C);
    // R6 ordering
    setm(1, 0);
    epp_run(1, 4, 2, 32'h11223344, "R6 4B write");
    setm(1, 0);
    epp_run(1, 4, 1, 32'hAAAA5566, "R6 2B write");
    setm(1, 0);
    epp_run(1, 3, 2, 32'h99887766, "R6 addr one byte");
    setm(2, 0);
    acc(1, 4, 0, 32'h7); chk("R10 epp latency", t_lat, 3);
    // R7 boundary, limit 3
    ack_limit = 3;
    setm(4, 0); epp_run(1, 4, 0, 32'h5A, "R7 last cycle ok");
    setm(5, 0); epp_run(1, 4, 0, 32'h5B, "R7 timeout");
    acc(1, 1, 0, 32'hFE); acc(0, 1, 0, 0); chk("R9 clear needs bit0", t_rd, 32'hA5);
    acc(1, 1, 0, 32'h01); tmo_e = 0; acc(0, 1, 0, 0); chk("R9 cleared", t_rd, 32'hA4);
    ack_limit = 0;
    setm(1, 0); epp_run(1, 4, 0, 32'h21, "R7 limit zero ok");
    setm(2, 0); epp_run(1, 4, 0, 32'h22, "R7 limit zero timeout");
    ack_limit = 3;
    // R8 error mid read
    acc(1, 2, 0, 32'h24); ctl_e = 8'hE4;
    setm(1, 0); m_err[1] = 1;
    epp_run(0, 4, 2, 0, "R8 error mid read");
    setm(1, 0); epp_run(0, 4, 2, 0, "R8 sticky after ok");
    acc(1, 1, 0, 32'h01); tmo_e = 0;
    setm(1, 0); m_dly[2] = 9;
    epp_run(0, 4, 2, 0, "R8 timeout mid read");
    // random
    for (int it = 0; it < 80; it++) begin
      int r;
      logic [7:0] cv;
      r = $urandom % 4;
      cv = (r == 0) ? 8'h04 : (r == 1) ? 8'h24 : (r == 2) ? 8'h2C : 8'($urandom);
      acc(1, 2, 0, {24'h0, cv});
      chk("R3 random ctrl pulse", t_cu, (cv | 8'hC0) != ctl_e);
      ctl_e = cv | 8'hC0;
      for (int i = 0; i < 4; i++) begin
        m_dly[i] = 1 + ($urandom % 6); m_err[i] = ($urandom % 10) == 0;
      end
      m_nlog = 0; m_byte = 0; m_pc = 0;
      epp_run($urandom % 2, ($urandom % 2) ? 3'd4 : 3'd3, 2'($urandom), $urandom, "R4 R5 R6 R7 R8 random");
      if ($urandom % 3 == 0) begin acc(1, 1, 0, 32'h01); tmo_e = 0; end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule